// File: doc/BRIEF.md
# Flash Command Decoder with Program Bypass and Query Window

This block sits on the write side of a two-bank NOR-style flash command interface and turns bus write cycles into decoded actions. It recognises the normal unlocked four-cycle program sequence, a bypass mode in which a program needs only a setup write and a data write, and a query mode that exposes a small code table in one bank while the other bank keeps returning array data. It does not erase, time cells, control voltages or suspend anything. It only emits strobes and mode flags for the logic that does.

A program request leaves the block as a one-cycle `prog_start` pulse. The pulse comes with the captured address and data and appears the cycle after the data write is sampled. Bypass and query state are registered flags. The read port is a combinational multiplexer. Reads that fall in the bank in query mode return a computed code. All other reads pass `array_rdata` through unchanged.

The bank is selected by the top address bit. Command cycles compare only the low 11 address bits and the low data byte.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Writing AAh at 555h, then 55h at 2AAh, then A0h at 555h, then any address/data write makes `prog_start` high for exactly one cycle after the fourth write. `prog_addr` and `prog_data` then hold that fourth write's address and data.
- R2: In the unlock sequence, a write that does not match the expected cycle returns the sequence to idle and has no other effect. This includes a 98h write after the first unlock cycle.
- R3: Writing AAh at 555h, then 55h at 2AAh, then 20h at 555h sets `bypass_on`.
- R4: While in bypass, an A0h write at any address followed by one address/data write produces a program pulse as in R1.
- R5: While in bypass, writes of 80h and 30h (erase codes) are ignored. Writes of 98h, F0h, AAh and any other data except A0h and 90h are also ignored. `bypass_on` stays set, query mode is not entered, and no program is issued.
- R6: Bypass ends only when a 90h write is followed by a 00h write whose top address bit equals that of the 90h write. A bank mismatch or other data keeps bypass active. After the exit the decoder is idle, and a lone A0h plus data no longer programs.
- R7: Outside bypass and with the sequence idle, a 98h write at any address sets `query_on` and loads `query_bank` with that write's top address bit. A 98h write while query is active is ignored and the bank is kept.
- R8: While query is active, reads whose top address bit equals `query_bank` return the code table in the low byte with the upper byte 0. The table index is `rd_addr[5:0]`. Index 10h gives 51h, 11h gives 52h, 12h gives 59h, and any other index i gives {2'b10, i}. If any address bit between bit 6 and the bank bit is set, the code is 00h. All other reads return `array_rdata`.
- R9: While query is active, only an F0h write has an effect, and it clears `query_on`. Program and bypass sequences written in query mode do nothing.
- R10: After reset, `prog_start`, `bypass_on`, `query_on` and `query_bank` are 0, the sequence is idle, and `rd_data` equals `array_rdata`.
- R11: The upper data byte and the address bits above bit 10 are ignored when matching command cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle valid this clock |
| wr_addr | input | 22 | Write address, bit 21 selects the bank |
| wr_data | input | 16 | Write data |
| rd_addr | input | 22 | Read address |
| array_rdata | input | 16 | Data read from the cell array |
| rd_data | output | 16 | Read data after query multiplexing |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | 22 | Captured program address |
| prog_data | output | 16 | Captured program data |
| bypass_on | output | 1 | Bypass (two-cycle program) mode active |
| query_on | output | 1 | Query mode active |
| query_bank | output | 1 | Bank that is in query mode |

## Verification
The bench goes after the bypass exit with the two cycles in different banks. A decoder that ignores the bank would drop out of bypass early, and later A0h writes would stop programming. It writes erase codes and the query code inside bypass. A decoder that honoured them would leave bypass or enter query while still in bypass. It sends a second 98h to the other bank while query is active. A design that re-latched the bank would move the code table to the wrong bank. It also interrupts the unlock sequence with a query code and with a wrong address. A decoder that did not fall back to idle would accept short sequences or enter query in the middle of a sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef struct packed {
    logic unl1;   // AAh at first unlock address
    logic unl2;   // 55h at second unlock address
    logic prog3;  // A0h at first unlock address
    logic byp3;   // 20h at first unlock address
    logic setup;  // A0h anywhere (bypass program setup)
    logic query;  // 98h anywhere
    logic rst;    // F0h anywhere
    logic bpr1;   // 90h anywhere
    logic bpr2;   // 00h anywhere
  } cmd_flags_t;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_UNL1   = 3'd1,
    S_UNL2   = 3'd2,
    S_PROG   = 3'd3,
    S_BP_IDL = 3'd4,
    S_BP_PRG = 3'd5,
    S_BP_RST = 3'd6
  } seq_state_t;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_QUERY = 8'h98;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_BPR1  = 8'h90;
  localparam logic [7:0] C_BPR2  = 8'h00;

  // Query code table, computed rather than stored.
  function automatic logic [7:0] query_code(input logic [5:0] idx);
    logic [7:0] code;
    case (idx)
      6'h10:   code = 8'h51;
      6'h11:   code = 8'h52;
      6'h12:   code = 8'h59;
      default: code = {2'b10, idx};
    endcase
    return code;
  endfunction

endpackage

// File: rtl/fcd_decode.sv
module fcd_decode
  import fcd_pkg::*;
#(
  parameter int CMD_AW = 11
) (
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_code,
  output cmd_flags_t        flags
);
  localparam logic [CMD_AW-1:0] ADDR_U1 = CMD_AW'(11'h555);
  localparam logic [CMD_AW-1:0] ADDR_U2 = CMD_AW'(11'h2AA);

  logic at_u1, at_u2;
  assign at_u1 = (cmd_addr == ADDR_U1);
  assign at_u2 = (cmd_addr == ADDR_U2);

  always_comb begin
    flags.unl1  = at_u1 && (cmd_code == C_UNL1);
    flags.unl2  = at_u2 && (cmd_code == C_UNL2);
    flags.prog3 = at_u1 && (cmd_code == C_PROG);
    flags.byp3  = at_u1 && (cmd_code == C_BYP);
    flags.setup = (cmd_code == C_PROG);
    flags.query = (cmd_code == C_QUERY);
    flags.rst   = (cmd_code == C_RESET);
    flags.bpr1  = (cmd_code == C_BPR1);
    flags.bpr2  = (cmd_code == C_BPR2);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cmd_flags_t cmd,
  input  logic       wr_bank,
  input  logic       query_on,
  output logic       ev_prog,
  output logic       ev_q_enter,
  output logic       ev_q_exit,
  output logic       bypass_on
);
  seq_state_t st, st_nxt;
  logic       rbank, rbank_nxt;

  always_comb begin
    st_nxt     = st;
    rbank_nxt  = rbank;
    ev_prog    = 1'b0;
    ev_q_enter = 1'b0;
    ev_q_exit  = 1'b0;
    if (wr_en) begin
      case (st)
        S_IDLE: begin
          if (query_on) begin
            if (cmd.rst) ev_q_exit = 1'b1;
          end else if (cmd.unl1) begin
            st_nxt = S_UNL1;
          end else if (cmd.query) begin
            ev_q_enter = 1'b1;
          end
        end
        S_UNL1: st_nxt = cmd.unl2 ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          if (cmd.prog3)     st_nxt = S_PROG;
          else if (cmd.byp3) st_nxt = S_BP_IDL;
          else               st_nxt = S_IDLE;
        end
        S_PROG: begin
          ev_prog = 1'b1;
          st_nxt  = S_IDLE;
        end
        S_BP_IDL: begin
          if (cmd.setup) begin
            st_nxt = S_BP_PRG;
          end else if (cmd.bpr1) begin
            st_nxt    = S_BP_RST;
            rbank_nxt = wr_bank;
          end
        end
        S_BP_PRG: begin
          ev_prog = 1'b1;
          st_nxt  = S_BP_IDL;
        end
        S_BP_RST: st_nxt = (cmd.bpr2 && (wr_bank == rbank)) ? S_IDLE : S_BP_IDL;
        default:  st_nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      rbank <= 1'b0;
    end else begin
      st    <= st_nxt;
      rbank <= rbank_nxt;
    end
  end

  assign bypass_on = (st == S_BP_IDL) || (st == S_BP_PRG) || (st == S_BP_RST);
endmodule

// File: rtl/fcd_query_port.sv
module fcd_query_port
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int ROM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_q_enter,
  input  logic              ev_q_exit,
  input  logic              enter_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              query_on,
  output logic              query_bank
);
  localparam int MID_W = ADDR_W - 1 - ROM_AW;

  logic              hit;
  logic [7:0]        code;
  logic [MID_W-1:0]  mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      query_on   <= 1'b0;
      query_bank <= 1'b0;
    end else if (ev_q_enter) begin
      query_on   <= 1'b1;
      query_bank <= enter_bank;
    end else if (ev_q_exit) begin
      query_on   <= 1'b0;
    end
  end

  assign mid  = rd_addr[ADDR_W-2:ROM_AW];
  assign hit  = query_on && (rd_addr[ADDR_W-1] == query_bank);
  assign code = (mid == '0) ? query_code(6'(rd_addr[ROM_AW-1:0])) : 8'h00;

  generate
    if (DATA_W > 8) begin : g_wide
      assign rd_data = hit ? {{(DATA_W-8){1'b0}}, code} : array_rdata;
    end else begin : g_byte
      assign rd_data = hit ? code[DATA_W-1:0] : array_rdata;
    end
  endgenerate
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CMD_AW = 11,
  parameter int ROM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              bypass_on,
  output logic              query_on,
  output logic              query_bank
);
  cmd_flags_t cmd;
  logic       wr_bank;
  logic       ev_prog, ev_q_enter, ev_q_exit;

  assign wr_bank = wr_addr[ADDR_W-1];

  fcd_decode #(.CMD_AW(CMD_AW)) u_dec (
    .cmd_addr (wr_addr[CMD_AW-1:0]),
    .cmd_code (wr_data[7:0]),
    .flags    (cmd)
  );

  fcd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cmd        (cmd),
    .wr_bank    (wr_bank),
    .query_on   (query_on),
    .ev_prog    (ev_prog),
    .ev_q_enter (ev_q_enter),
    .ev_q_exit  (ev_q_exit),
    .bypass_on  (bypass_on)
  );

  fcd_query_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW)) u_qry (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_q_enter  (ev_q_enter),
    .ev_q_exit   (ev_q_exit),
    .enter_bank  (wr_bank),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .query_on    (query_on),
    .query_bank  (query_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_start <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      prog_start <= ev_prog;
      if (ev_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_bank,
  input logic [DATA_W-1:0] array_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              prog_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              bypass_on,
  input logic              query_on,
  input logic              query_bank,
  input logic              ev_prog
);
  AST_PROG_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start); // R1
  AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(wr_en) && prog_addr == $past(wr_addr) && prog_data == $past(wr_data))); // R1
  AST_EV_PROG_TO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> prog_start); // R4
  AST_NO_QUERY_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass_on && query_on)); // R5
  AST_ERASE_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_on && wr_en && (wr_data[7:0] == 8'h80 || wr_data[7:0] == 8'h30)) |=> bypass_on); // R5
  AST_BYPASS_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_on) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h00)); // R6
  AST_QUERY_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (query_on && $past(query_on)) |-> $stable(query_bank)); // R7
  AST_QUERY_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(query_on) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'hF0)); // R9
  AST_QUERY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (query_on && rd_bank == query_bank) |-> (rd_data[DATA_W-1:8] == '0)); // R8
  AST_OTHER_BANK_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!query_on || rd_bank != query_bank) |-> (rd_data == array_rdata)); // R8
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_bank     (rd_addr[ADDR_W-1]),
  .array_rdata (array_rdata),
  .rd_data     (rd_data),
  .prog_start  (prog_start),
  .prog_addr   (prog_addr),
  .prog_data   (prog_data),
  .bypass_on   (bypass_on),
  .query_on    (query_on),
  .query_bank  (query_bank),
  .ev_prog     (ev_prog)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] array_rdata = '0;
  logic [DW-1:0] rd_data;
  logic          prog_start;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          bypass_on, query_on, query_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side expectation state
  bit            m_byp, m_q, m_qb, m_rb, e_prog;
  int            m_step;
  logic [AW-1:0] e_pa;
  logic [DW-1:0] e_pd;

  always #2 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .bypass_on(bypass_on), .query_on(query_on), .query_bank(query_bank)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [AW-1:0] a);
    logic [5:0] i = a[5:0];
    if (a[AW-2:6] != '0) return 8'h00;
    if (i == 6'h10) return 8'h51;
    if (i == 6'h11) return 8'h52;
    if (i == 6'h12) return 8'h59;
    return 8'h80 | {2'b00, i};
  endfunction

  function automatic bit at(input logic [AW-1:0] a, input logic [10:0] v);
    return a[10:0] == v;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [7:0] c = d[7:0];
    bit bk = a[AW-1];
    e_prog = 1'b0;
    if (!m_byp) begin
      case (m_step)
        0: if (m_q) begin
             if (c == 8'hF0) m_q = 1'b0;
           end else if (c == 8'hAA && at(a, 11'h555)) m_step = 1;
           else if (c == 8'h98) begin m_q = 1'b1; m_qb = bk; end
        1: m_step = (c == 8'h55 && at(a, 11'h2AA)) ? 2 : 0;
        2: begin
             if (c == 8'hA0 && at(a, 11'h555)) m_step = 3;
             else if (c == 8'h20 && at(a, 11'h555)) begin m_byp = 1'b1; m_step = 0; end
             else m_step = 0;
           end
        default: begin e_prog = 1'b1; e_pa = a; e_pd = d; m_step = 0; end
      endcase
    end else begin
      case (m_step)
        0: if (c == 8'hA0) m_step = 1;
           else if (c == 8'h90) begin m_step = 2; m_rb = bk; end
        1: begin e_prog = 1'b1; e_pa = a; e_pd = d; m_step = 0; end
        default: begin
          if (c == 8'h00 && bk == m_rb) m_byp = 1'b0;
          m_step = 0;
        end
      endcase
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "prog_start", 32'(prog_start), 32'(e_prog));
    if (e_prog) begin
      chk(req, "prog_addr", 32'(prog_addr), 32'(e_pa));
      chk(req, "prog_data", 32'(prog_data), 32'(e_pd));
    end
    chk(req, "bypass_on", 32'(bypass_on), 32'(m_byp));
    chk(req, "query_on", 32'(query_on), 32'(m_q));
    if (m_q) chk(req, "query_bank", 32'(query_bank), 32'(m_qb));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_state(req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, input string req);
    logic [DW-1:0] exp;
    rd_addr = a; array_rdata = arr;
    #1;
    if (m_q && a[AW-1] == m_qb) exp = {8'h00, exp_code(a)};
    else exp = arr;
    chk(req, "rd_data", 32'(rd_data), 32'(exp));
  endtask

  localparam logic [AW-1:0] B1 = AW'(1) << (AW-1);

  task automatic unlock(input logic [7:0] third, input string req);
    wr(22'h000555, 16'h00AA, req);
    wr(22'h0002AA, 16'h0055, req);
    wr(22'h000555, {8'h00, third}, req);
  endtask

  initial begin
    logic [7:0] c;
    logic [AW-1:0] a;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "prog_start", 32'(prog_start), 0);
    chk("R10", "bypass_on", 32'(bypass_on), 0);
    chk("R10", "query_on", 32'(query_on), 0);
    chk("R10", "query_bank", 32'(query_bank), 0);
    rd(B1 | 22'h10, 16'hC3C3, "R10");

    // R1 four-cycle program and single pulse
    unlock(8'hA0, "R1");
    wr(22'h3F1234, 16'hBEEF, "R1");
    @(negedge clk);
    chk("R1", "prog_start after pulse", 32'(prog_start), 0);

    // R2 broken sequences
    wr(22'h000555, 16'h00AA, "R2");
    wr(22'h0002AA, 16'h0055, "R2");
    wr(22'h000556, 16'h00A0, "R2");
    wr(22'h001000, 16'h1111, "R2");
    wr(22'h000555, 16'h00AA, "R2");
    wr(B1 | 22'h000055, 16'h0098, "R2");
    chk("R2", "no query mid-sequence", 32'(query_on), 0);

    // R11 ignored high bits
    wr(22'h2AB555, 16'h12AA, "R11");
    wr(22'h1F82AA, 16'hFF55, "R11");
    wr(22'h0AA555, 16'h77A0, "R11");
    wr(22'h000042, 16'h4242, "R11");

    // R3 enter bypass, R4 two-cycle programs
    unlock(8'h20, "R3");
    chk("R3", "bypass set", 32'(bypass_on), 1);
    wr(22'h123456, 16'h00A0, "R4");
    wr(22'h2ABCDE, 16'h5A5A, "R4");
    wr(B1 | 22'h000777, 16'h00A0, "R4");
    wr(B1 | 22'h000001, 16'h0001, "R4");

    // R5 ignored commands in bypass
    wr(22'h000555, 16'h0080, "R5");
    wr(22'h000555, 16'h0030, "R5");
    wr(22'h000055, 16'h0098, "R5");
    wr(22'h000000, 16'h00F0, "R5");
    wr(22'h000555, 16'h00AA, "R5");
    chk("R5", "bypass kept", 32'(bypass_on), 1);
    wr(22'h000100, 16'h00A0, "R5");
    wr(22'h000200, 16'hCAFE, "R5");

    // R6 exit rules
    wr(22'h000000, 16'h0090, "R6");
    wr(B1, 16'h0000, "R6");
    chk("R6", "bank mismatch keeps bypass", 32'(bypass_on), 1);
    wr(B1, 16'h0090, "R6");
    wr(B1, 16'h0055, "R6");
    wr(B1 | 22'h0000AA, 16'h0090, "R6");
    wr(B1 | 22'h000123, 16'h0000, "R6");
    chk("R6", "bypass cleared", 32'(bypass_on), 0);
    wr(22'h000300, 16'h00A0, "R6");
    wr(22'h000301, 16'h9999, "R6");

    // R7 query entry, R8 reads
    wr(B1 | 22'h000055, 16'h0098, "R7");
    chk("R7", "query bank", 32'(query_bank), 1);
    wr(22'h000055, 16'h0098, "R7");
    chk("R7", "bank kept", 32'(query_bank), 1);
    rd(B1 | 22'h10, 16'hFFFF, "R8");
    rd(B1 | 22'h11, 16'hFFFF, "R8");
    rd(B1 | 22'h12, 16'hFFFF, "R8");
    rd(B1 | 22'h05, 16'hFFFF, "R8");
    rd(B1 | 22'h000450, 16'hFFFF, "R8");
    rd(22'h000010, 16'hA5A5, "R8");

    // R9 only reset leaves query
    unlock(8'hA0, "R9");
    wr(22'h000040, 16'h1234, "R9");
    unlock(8'h20, "R9");
    chk("R9", "no bypass in query", 32'(bypass_on), 0);
    wr(22'h000000, 16'h00F0, "R9");
    chk("R9", "query cleared", 32'(query_on), 0);
    rd(B1 | 22'h10, 16'h3C3C, "R9");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      case ($urandom % 12)
        0: c = 8'hAA; 1: c = 8'h55; 2: c = 8'hA0; 3: c = 8'h20;
        4: c = 8'h90; 5: c = 8'h00; 6: c = 8'h98; 7: c = 8'hF0;
        8: c = 8'h80; 9: c = 8'h30;
        default: c = 8'($urandom);
      endcase
      a = AW'($urandom);
      case ($urandom % 4)
        0: a[10:0] = 11'h555;
        1: a[10:0] = 11'h2AA;
        default: ;
      endcase
      if ($urandom % 2 == 0) a[AW-2:11] = '0;
      wr(a, {8'($urandom), c}, "R1/R2/R4/R5/R6/R7/R9");
      a = AW'($urandom);
      if ($urandom % 2 == 0) a[AW-2:6] = '0;
      rd(a, 16'($urandom), "R8");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule